// File: doc/BRIEF.md
# Bit-banged I2C serial EEPROM read slave

This block models the slave side of a small I2C serial EEPROM holding 256 bytes. A host drives the two bus lines by writing register values: every cycle with `line_wr` high presents a new pair of SCL and SDA levels. The slave compares each pair with the levels it remembers, sees START and STOP conditions and rising clock edges, and walks a single bit counter through an 8-bit command byte and an 8-bit word address. The level the host reads back on `sda_rd` is the level the slave last stored. That is the host's own level, except where the slave forces an acknowledge low or drives read data.

Only the control sequence and addressed reads are modelled, and the storage is read-only. When the eighth address bit arrives, the byte at the assembled address is latched into a data register. During the address phase of the next read command, that byte shifts out MSB first, one bit per sampled edge. The lower 128 bytes hold a computed preload pattern and the upper 128 bytes read as zero.

Top module: `i2c_rom_slave`

## Requirements
- R1: After reset `sda_rd` is 1, the counter is idle with no acknowledge pending, and the data register holds 0x00, so the first read transaction shifts out eight 0 bits.
- R2: A START (SDA from 1 to 0 while SCL is high before and after) sets the bit counter to 1 and clears the command byte, so the next eight sampled bits form the command.
- R3: A STOP (SDA from 0 to 1 while SCL stays high) leaves the bit counter and the command unchanged, so a transaction continues across it.
- R4: While the counter is 0 and no acknowledge is pending, anything other than a START changes no state except the remembered line levels.
- R5: A bit is sampled only on a rising SCL write whose SDA equals the remembered SDA. A rising edge that also changes SDA is not counted.
- R6: After the eighth command bit an acknowledge is pending. The next rising SCL write forces `sda_rd` to 0 whatever the host drives, and clears the pending acknowledge without advancing the counter.
- R7: Each of the eight address bits is shifted into the address register MSB first. On each of these sampled edges the data register shifts left. If command bit 0 is 1 (read), `sda_rd` shows the data register's MSB from before the shift.
- R8: On the eighth address bit the data register loads the stored byte at the assembled address, an acknowledge is scheduled (the next rising edge gives `sda_rd` = 0), and the counter returns to 0.
- R9: The stored byte at address a is (37*a + 90) mod 256 for a < 128, and 0x00 for a >= 128.
- R10: When the slave forces nothing, `sda_rd` equals the SDA level of the most recent host write. This includes the address phase of a write command (bit 0 = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_wr | input | 1 | Host presents a new SCL/SDA pair this cycle |
| scl_in | input | 1 | SCL level written by the host |
| sda_in | input | 1 | SDA level written by the host |
| sda_rd | output | 1 | SDA level read back by the host |

## Verification
The bench sweeps every one of the 256 addresses in a chained sequence of read transactions. Each transaction reveals the byte latched by the one before it, so a wrong preload formula, a missing upper-half zero or a load from the pre-shift address shows up as a wrong byte.

It also targets several protocol corner cases:
- A rising edge that changes SDA is placed inside the command. A design that counted it would acknowledge one bit early and turn the read bit into a 0.
- A STOP is placed after the first address bit. A design that restarted the counter would never acknowledge the address and would not load the byte.
- Idle clocking between transactions must neither acknowledge nor hide the host level.
- Write commands must pass the host level straight back instead of data bits.

// File: rtl/rom_slave_pkg.sv
// Package: shared event type and preload constants for the EEPROM read slave.
// Assumes the preload pattern is an affine function of the address.
package rom_slave_pkg;
    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_STOP,
        EV_RISE,
        EV_OTHER
    } line_ev_e;

    localparam int unsigned PRELOAD_MUL = 37;
    localparam int unsigned PRELOAD_ADD = 90;

    // Preload value for one address, before truncation to the data width.
    function automatic int unsigned preload_value(input int unsigned a);
        return a * PRELOAD_MUL + PRELOAD_ADD;
    endfunction
endpackage

// File: rtl/rom_line_events.sv
// Classifies a host line write against the remembered SCL/SDA levels.
// Assumes the remembered levels are the ones the slave last stored.
// Purely combinational.
module rom_line_events
    import rom_slave_pkg::*;
(
    input  logic     line_wr,
    input  logic     scl_in,
    input  logic     sda_in,
    input  logic     scl_q,
    input  logic     sda_q,
    output line_ev_e ev,
    output logic     sda_same
);
    // Decode the kind of bus event this write represents.
    always_comb begin
        ev = EV_NONE;
        if (line_wr) begin
            if (scl_q && scl_in && (sda_q != sda_in))
                ev = sda_in ? EV_STOP : EV_START;
            else if (!scl_q && scl_in)
                ev = EV_RISE;
            else
                ev = EV_OTHER;
        end
    end

    assign sda_same = (sda_q == sda_in);
endmodule

// File: rtl/rom_slave_store.sv
// Read-only byte storage with a computed preload over the lower part.
// Assumes no write path; the read is combinational on the address.
module rom_slave_store
    import rom_slave_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int PRELOAD_DEPTH = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    generate
        if (PRELOAD_DEPTH >= DEPTH) begin : g_full
            // Whole array carries the preload pattern.
            always_comb q = DATA_W'(preload_value(int'(addr)));
        end else begin : g_part
            // Lower part preloaded, upper part reads as zero.
            always_comb
                q = (int'(addr) < PRELOAD_DEPTH) ? DATA_W'(preload_value(int'(addr)))
                                                 : '0;
        end
    endgenerate
endmodule

// File: rtl/i2c_rom_slave.sv
// Bit-level I2C EEPROM slave: command, word address, addressed read-out.
// Assumes the host updates SCL/SDA through single-cycle line_wr strobes
// and reads back the stored SDA level on sda_rd.
module i2c_rom_slave
    import rom_slave_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int PRELOAD_DEPTH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_wr,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_rd
);
    localparam int CMD_END  = DATA_W + 1;
    localparam int ADDR_END = CMD_END + ADDR_W;
    localparam int TICK_W   = $clog2(ADDR_END + 1);
    localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_END);
    localparam logic [TICK_W-1:0] T_ADDR = TICK_W'(ADDR_END);

    logic              scl_q, sda_q, ack_q;
    logic [TICK_W-1:0] tick_q;
    logic [DATA_W-1:0] cmd_q, data_q;
    logic [ADDR_W-1:0] addr_q;

    logic              scl_d, sda_d, ack_d;
    logic [TICK_W-1:0] tick_d, tick_inc;
    logic [DATA_W-1:0] cmd_d, data_d, rom_q;
    logic [ADDR_W-1:0] addr_d, addr_sh;
    line_ev_e          ev;
    logic              sda_same;

    rom_line_events u_ev (
        .line_wr (line_wr),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_q   (scl_q),
        .sda_q   (sda_q),
        .ev      (ev),
        .sda_same(sda_same)
    );

    assign addr_sh  = {addr_q[ADDR_W-2:0], sda_in};
    assign tick_inc = tick_q + T_ONE;

    rom_slave_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_DEPTH(PRELOAD_DEPTH)
    ) u_store (
        .addr(addr_sh),
        .q   (rom_q)
    );

    // Next-state sequencing for counter, acknowledge and shift registers.
    always_comb begin
        scl_d  = scl_q;
        sda_d  = sda_q;
        ack_d  = ack_q;
        tick_d = tick_q;
        cmd_d  = cmd_q;
        addr_d = addr_q;
        data_d = data_q;
        if (line_wr) begin
            scl_d = scl_in;
            sda_d = sda_in;
            if (ev == EV_START) begin
                tick_d = T_ONE;
                cmd_d  = '0;
            end else if (ev == EV_STOP) begin
                tick_d = tick_q;
            end else if (tick_q == '0 && !ack_q) begin
                tick_d = tick_q;
            end else if (ev == EV_RISE) begin
                if (ack_q) begin
                    sda_d = 1'b0;
                    ack_d = 1'b0;
                end else if (sda_same) begin
                    if (tick_q < T_CMD) begin
                        cmd_d  = {cmd_q[DATA_W-2:0], sda_in};
                        tick_d = tick_inc;
                        if (tick_inc == T_CMD) ack_d = 1'b1;
                    end else begin
                        if (cmd_q[0]) sda_d = data_q[DATA_W-1];
                        addr_d = addr_sh;
                        data_d = data_q << 1;
                        tick_d = tick_inc;
                        if (tick_inc == T_ADDR) begin
                            data_d = rom_q;
                            ack_d  = 1'b1;
                            tick_d = '0;
                        end
                    end
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            ack_q  <= 1'b0;
            tick_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            scl_q  <= scl_d;
            sda_q  <= sda_d;
            ack_q  <= ack_d;
            tick_q <= tick_d;
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign sda_rd = sda_q;

    // R2: a START restarts the counter at one with an empty command.
    p_start_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_START |=> tick_q == T_ONE && cmd_q == '0);

    // R3: a STOP leaves the counter untouched.
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_STOP |=> $stable(tick_q) && $stable(cmd_q));

    // R4: idle with no acknowledge ignores everything but START.
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr && ev != EV_START && tick_q == '0 && !ack_q)
        |=> tick_q == '0 && !ack_q && $stable(addr_q) && $stable(data_q));

    // R5: a rising edge that also moves SDA is not a bit.
    p_edge_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RISE && !sda_same && !ack_q) |=> $stable(tick_q));

    // R6: a pending acknowledge drives SDA low on the next rising edge.
    p_ack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RISE && ack_q) |=> !sda_rd && !ack_q && $stable(tick_q));

    // R8: the last address bit returns the counter to idle with an acknowledge.
    p_load_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RISE && !ack_q && sda_same && tick_inc == T_ADDR)
        |=> tick_q == '0 && ack_q);

    // R10: without a host write the read-back level holds.
    p_hold_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr |=> $stable(sda_rd));

    // R7: the counter never passes the last address position.
    p_tick_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q < T_ADDR);
endmodule

// File: tb/i2c_rom_slave_tb.sv
module i2c_rom_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_wr = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_rd;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] held = 8'h00;

    always #4 clk = ~clk;

    i2c_rom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .line_wr(line_wr),
        .scl_in(scl_in), .sda_in(sda_in), .sda_rd(sda_rd)
    );

    function automatic logic [7:0] exp_byte(input int a);
        return (a < 128) ? 8'((a * 37 + 90) % 256) : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic d);
        @(negedge clk);
        line_wr = 1'b1; scl_in = c; sda_in = d;
        @(negedge clk);
        line_wr = 1'b0;
    endtask

    task automatic send_bit(input logic b, output logic got);
        wr(1'b0, b);
        wr(1'b1, b);
        got = sda_rd;
        wr(1'b0, b);
    endtask

    // One transaction: START, command, ack, address, ack.
    // glitch: insert a rising edge that moves SDA inside the command.
    // stop_mid: after the first address bit (must be 0) place a STOP.
    task automatic txn(input logic rd, input logic [7:0] a, input bit glitch,
                       input bit stop_mid);
        logic [7:0] cmd, got_byte;
        logic g;
        cmd = {7'b1010000, rd};
        wr(1'b1, 1'b1);
        wr(1'b1, 1'b0);
        wr(1'b0, 1'b0);
        for (int i = 7; i >= 0; i--) begin
            if (glitch && i == 3) begin
                wr(1'b0, 1'b1);
                wr(1'b1, 1'b0);
                wr(1'b0, 1'b0);
            end
            send_bit(cmd[i], g);
            if (i == 0) check("R5 last command bit level", {7'b0, g}, {7'b0, rd});
        end
        send_bit(1'b1, g);
        check("R6 command ack", {7'b0, g}, 8'h00);
        for (int i = 7; i >= 0; i--) begin
            if (stop_mid && i == 7) begin
                wr(1'b0, a[7]);
                wr(1'b1, a[7]);
                g = sda_rd;
                wr(1'b1, 1'b1);
                wr(1'b0, 1'b1);
            end else begin
                send_bit(a[i], g);
            end
            got_byte[i] = g;
        end
        if (rd) check("R7 R9 read-out byte", got_byte, held);
        else    check("R10 write-command echo", got_byte, a);
        send_bit(1'b1, g);
        check("R8 address ack", {7'b0, g}, 8'h00);
        held = exp_byte(int'(a));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sda_rd", {7'b0, sda_rd}, 8'h01);

        // R4 R10: idle clocking is ignored and echoes host level.
        for (int i = 0; i < 6; i++) begin
            send_bit(i[0], g);
            check("R4 idle echo", {7'b0, g}, {7'b0, i[0]});
        end

        // R1: first read shows the reset data register (0x00).
        txn(1'b1, 8'h10, 1'b0, 1'b0);

        // R2 R7 R9: chained sweep of every address.
        for (int k = 0; k < 256; k++)
            txn(1'b1, 8'((k * 53 + 7) % 256), (k % 37) == 5, 1'b0);

        // R3 R10: write command with a STOP inside the address phase.
        txn(1'b0, 8'h5A, 1'b0, 1'b1);
        txn(1'b1, 8'h81, 1'b0, 1'b0);

        // R4: idle activity after a transaction, then verify state intact.
        for (int i = 0; i < 4; i++) begin
            send_bit(1'b1, g);
            check("R4 idle no ack", {7'b0, g}, 8'h01);
        end
        txn(1'b1, 8'h00, 1'b1, 1'b0);
        txn(1'b1, 8'h7F, 1'b0, 1'b0);
        txn(1'b1, 8'hFF, 1'b0, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule